// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

The block keeps wall-clock time as packed two-digit BCD bytes: seconds, minutes, hours, day of month, month, a two-digit year standing for 2000 to 2099, and a day-of-week count. A prescaler counts enables from a 32768 Hz time base. Every `TICKS_PER_SEC` enables it produces one second step. The step ripples through the fields with month-length and leap-year aware rollover. Hours count in 24-hour or 12-hour form, and in 12-hour form bit 7 of the hour byte is the PM flag.

Any field can be written at any time through a shared data byte and a per-field strobe. A window flag warns software that a second update is about to happen. Six alarm bytes are compared with the time after each second step. A match on all six gives a single-cycle alarm pulse. Separate pulses mark each second, minute, hour and day boundary.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset: seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x00. All event outputs, `alarm_o` and `busy_o` are low. All alarm bytes are 0x00.
- R2: While `run_i` is high, every `TICKS_PER_SEC`-th cycle with `tick32k_i` high is a second step. On the clock edge that samples that enable, the seconds advance and `ev_sec_o` goes high for exactly that one following cycle.
- R3: While `run_i` is low, the prescaler and all time fields hold. A write strobe still stores its byte.
- R4: `busy_o` is high exactly when `run_i` is high and the prescaler stands at its last count. That is the enable period that ends with a second step.
- R5: Seconds and minutes count 0x00..0x59 in BCD. `ev_min_o` pulses with `ev_sec_o` when the seconds wrap. `ev_hour_o` pulses with them when the minutes also wrap.
- R6: With `mode12_i` low, hours count 0x00..0x23. A wrap from 0x23 advances the day and pulses `ev_day_o` alongside `ev_hour_o`.
- R7: With `mode12_i` high, hour bits 6:0 count 0x12, 0x01 .. 0x11, then 0x12 again. Bit 7 (PM) toggles on the 0x11 to 0x12 step. The day advances only when PM goes from 1 to 0.
- R8: The day wraps to 0x01 after 0x31, 0x30 (months 0x04, 0x06, 0x09, 0x11) or February's last day. February's last day is 0x29 when the year's decimal value is divisible by 4 and 0x28 otherwise. Months count 0x01..0x12. The year counts 0x00..0x99 and wraps.
- R9: The weekday counts 0x00..0x06 and advances together with the day of month.
- R10: A write strobe stores `wr_data_i` into its field at the next edge, exactly as given. The stored value may be out of range or hold a digit above 9. On the next step, such a field, or a field at its last value, goes to its first value and carries. In 12-hour mode, an hour whose low 7 bits are 0x00, above 0x12, or a non-decimal digit goes to 0x12 with PM kept and no carry.
- R11: The alarm bytes (second, minute, hour including bit 7, day, month, year) are written by their own strobes. `alarm_o` is high for one cycle, the cycle after an `ev_sec_o` pulse, when all six bytes equal the time. No field is ignored. Writing the time to equal the alarm does not fire it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick32k_i | input | 1 | One-cycle enable per 32768 Hz period |
| run_i | input | 1 | Clock runs when high, holds when low |
| mode12_i | input | 1 | 1: 12-hour hours, 0: 24-hour hours |
| wr_data_i | input | 8 | Data byte for all field writes |
| wr_sec_i | input | 1 | Write seconds |
| wr_min_i | input | 1 | Write minutes |
| wr_hour_i | input | 1 | Write hours |
| wr_day_i | input | 1 | Write day of month |
| wr_mon_i | input | 1 | Write month |
| wr_year_i | input | 1 | Write year |
| wr_wday_i | input | 1 | Write weekday |
| alm_sec_i | input | 1 | Write alarm seconds |
| alm_min_i | input | 1 | Write alarm minutes |
| alm_hour_i | input | 1 | Write alarm hours |
| alm_day_i | input | 1 | Write alarm day |
| alm_mon_i | input | 1 | Write alarm month |
| alm_year_i | input | 1 | Write alarm year |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, bit 7 PM in 12-hour mode |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within century, BCD |
| wday_o | output | 8 | Weekday 0..6 |
| busy_o | output | 1 | Update window flag |
| ev_sec_o | output | 1 | Second boundary pulse |
| ev_min_o | output | 1 | Minute boundary pulse |
| ev_hour_o | output | 1 | Hour boundary pulse |
| ev_day_o | output | 1 | Day boundary pulse |
| alarm_o | output | 1 | Alarm match pulse |

## Verification
Time fields and the four boundary pulses change one edge after the cycle in which the last prescaler enable is presented. A written byte shows one edge after its strobe. `busy_o` follows the prescaler count and `run_i` in the same cycle with no register. `alarm_o` comes one edge later than `ev_sec_o`, because it compares the already updated time. The bench steps a behavioural model on every rising edge from the inputs it drove, and compares every output at the following falling edge. Each due cycle is therefore met without counting delays by hand.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 7;   // sec,min,hour,day,mon,year,wday
  localparam int NUM_ALARM  = 6;   // sec..year
  localparam int BYTE_W     = 8;

  typedef logic [BYTE_W-1:0] bcd_t;
  typedef struct packed {
    bcd_t nxt;
    logic cy;
  } step_t;

  function automatic logic bad_bcd(input bcd_t v);
    return (v[3:0] > 4'd9) || (v[7:4] > 4'd9);
  endfunction

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // plain field: last value or anything illegal wraps to first and carries
  function automatic step_t field_step(input bcd_t v, input bcd_t first, input bcd_t last);
    step_t s;
    if (bad_bcd(v) || v < first || v >= last) begin
      s.nxt = first;
      s.cy  = 1'b1;
    end else begin
      s.nxt = bcd_inc(v);
      s.cy  = 1'b0;
    end
    return s;
  endfunction

  function automatic step_t hour12_step(input bcd_t v);
    step_t s;
    logic [6:0] h;
    h    = v[6:0];
    s.cy = 1'b0;
    if (h == 7'h11) begin
      s.nxt = {~v[7], 7'h12};
      s.cy  = v[7];
    end else if (h == 7'h12) begin
      s.nxt = {v[7], 7'h01};
    end else if (h == 7'h00 || h > 7'h12 || h[3:0] > 4'd9) begin
      s.nxt = {v[7], 7'h12};
    end else begin
      s.nxt = bcd_inc({1'b0, h}) | {v[7], 7'h00};
    end
    return s;
  endfunction

  function automatic bcd_t month_last_day(input bcd_t mon, input bcd_t yr);
    logic [7:0] yb;
    yb = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                     return (yb % 8'd4 == 8'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  output logic step_o,
  output logic busy_o
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign busy_o  = run_i & at_last;
  assign step_o  = run_i & en_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (run_i & en_i) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end

  a_r3_prescale_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> $stable(cnt_q));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        step_i,
  input  logic                        mode12_i,
  input  logic [NUM_FIELDS-1:0]       wr_i,
  input  bcd_t                        wr_data_i,
  output logic [NUM_FIELDS-1:0][7:0]  fld_o,
  output logic [3:0]                  ev_o     // {day,hour,min,sec}
);
  localparam logic [NUM_FIELDS-1:0][7:0] RST_VAL =
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NUM_FIELDS-1:0][7:0] fld_q;
  step_t                      st [NUM_FIELDS];
  logic [NUM_FIELDS-1:0]      adv;
  logic [3:0]                 ev_q;

  always_comb begin
    st[0] = field_step(fld_q[0], 8'h00, 8'h59);
    st[1] = field_step(fld_q[1], 8'h00, 8'h59);
    st[2] = mode12_i ? hour12_step(fld_q[2]) : field_step(fld_q[2], 8'h00, 8'h23);
    st[3] = field_step(fld_q[3], 8'h01, month_last_day(fld_q[4], fld_q[5]));
    st[4] = field_step(fld_q[4], 8'h01, 8'h12);
    st[5] = field_step(fld_q[5], 8'h00, 8'h99);
    st[6] = field_step(fld_q[6], 8'h00, 8'h06);
    adv[0] = step_i;
    adv[1] = adv[0] & st[0].cy;
    adv[2] = adv[1] & st[1].cy;
    adv[3] = adv[2] & st[2].cy;
    adv[4] = adv[3] & st[3].cy;
    adv[5] = adv[4] & st[4].cy;
    adv[6] = adv[3];             // weekday moves with the date
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q <= RST_VAL;
      ev_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (wr_i[i])      fld_q[i] <= wr_data_i;
        else if (adv[i])  fld_q[i] <= st[i].nxt;
      end
      ev_q <= adv[3:0];
    end
  end

  assign fld_o = fld_q;
  assign ev_o  = ev_q;

  a_r3_sec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(step_i) && !$past(wr_i[0])) |-> $stable(fld_q[0]));
  a_r5_min_with_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q[1] |-> ev_q[0]);
  a_r6_day_with_hour: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q[3] |-> ev_q[2]);
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_ALARM-1:0]       wr_i,
  input  bcd_t                       wr_data_i,
  input  logic [NUM_ALARM-1:0][7:0]  time_i,
  input  logic                       ev_sec_i,
  output logic                       alarm_o
);
  logic [NUM_ALARM-1:0] eq;
  logic                 alarm_q;

  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_fld
    bcd_t al_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    al_q <= '0;
      else if (wr_i[g]) al_q <= wr_data_i;
    end
    assign eq[g] = (al_q == time_i[g]);
  end

  // compares the time already updated by the second step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= ev_sec_i & (&eq);
  end

  assign alarm_o = alarm_q;

  a_r11_after_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q |-> $past(ev_sec_i));
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q |=> !alarm_q);
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick32k_i,
  input  logic       run_i,
  input  logic       mode12_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_sec_i,
  input  logic       wr_min_i,
  input  logic       wr_hour_i,
  input  logic       wr_day_i,
  input  logic       wr_mon_i,
  input  logic       wr_year_i,
  input  logic       wr_wday_i,
  input  logic       alm_sec_i,
  input  logic       alm_min_i,
  input  logic       alm_hour_i,
  input  logic       alm_day_i,
  input  logic       alm_mon_i,
  input  logic       alm_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [7:0] wday_o,
  output logic       busy_o,
  output logic       ev_sec_o,
  output logic       ev_min_o,
  output logic       ev_hour_o,
  output logic       ev_day_o,
  output logic       alarm_o
);
  logic                       step;
  logic [NUM_FIELDS-1:0][7:0] fld;
  logic [3:0]                 ev;
  logic [NUM_FIELDS-1:0]      wr;
  logic [NUM_ALARM-1:0]       awr;

  assign wr  = {wr_wday_i, wr_year_i, wr_mon_i, wr_day_i, wr_hour_i, wr_min_i, wr_sec_i};
  assign awr = {alm_year_i, alm_mon_i, alm_day_i, alm_hour_i, alm_min_i, alm_sec_i};

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_pre (
    .clk_i, .rst_ni, .en_i(tick32k_i), .run_i, .step_o(step), .busy_o
  );

  rtc_calendar i_cal (
    .clk_i, .rst_ni, .step_i(step), .mode12_i, .wr_i(wr), .wr_data_i,
    .fld_o(fld), .ev_o(ev)
  );

  rtc_alarm i_alm (
    .clk_i, .rst_ni, .wr_i(awr), .wr_data_i, .time_i(fld[NUM_ALARM-1:0]),
    .ev_sec_i(ev[0]), .alarm_o
  );

  assign {wday_o, year_o, mon_o, day_o, hour_o, min_o, sec_o} = fld;
  assign {ev_day_o, ev_hour_o, ev_min_o, ev_sec_o} = ev;

  a_r4_busy_leads_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_sec_o |-> $past(busy_o));
endmodule

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick32k_i = 1'b0, run_i = 1'b0, mode12_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [6:0] wr = '0;
  logic [5:0] awr = '0;
  logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o, wday_o;
  logic       busy_o, ev_sec_o, ev_min_o, ev_hour_o, ev_day_o, alarm_o;

  int n_chk = 0, n_bad = 0, al_seen = 0;
  bit en_auto = 0;

  int         m_pre;
  logic [7:0] m_f [7];
  logic [7:0] m_al [6];
  bit         m_ev [4];
  bit         m_alarm;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TPS)) i_rtc_bcd_calendar (
    .clk_i, .rst_ni, .tick32k_i, .run_i, .mode12_i, .wr_data_i,
    .wr_sec_i(wr[0]), .wr_min_i(wr[1]), .wr_hour_i(wr[2]), .wr_day_i(wr[3]),
    .wr_mon_i(wr[4]), .wr_year_i(wr[5]), .wr_wday_i(wr[6]),
    .alm_sec_i(awr[0]), .alm_min_i(awr[1]), .alm_hour_i(awr[2]),
    .alm_day_i(awr[3]), .alm_mon_i(awr[4]), .alm_year_i(awr[5]),
    .sec_o, .min_o, .hour_o, .day_o, .mon_o, .year_o, .wday_o,
    .busy_o, .ev_sec_o, .ev_min_o, .ev_hour_o, .ev_day_o, .alarm_o
  );

  function automatic int dec(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic bit digits_ok(input logic [7:0] v);
    return (v[7:4] < 4'd10) && (v[3:0] < 4'd10);
  endfunction
  function automatic logic [7:0] enc(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  task automatic nxt_plain(inout logic [7:0] v, input int lo, input int hi, output bit cy);
    int n = dec(v);
    if (!digits_ok(v) || n < lo || n >= hi) begin v = enc(lo); cy = 1; end
    else begin v = enc(n + 1); cy = 0; end
  endtask

  task automatic nxt_h12(inout logic [7:0] v, output bit cy);
    logic [7:0] h = {1'b0, v[6:0]};
    bit pm = v[7];
    int n = dec(h);
    cy = 0;
    if (!digits_ok(h) || n == 0 || n > 12) v = {pm, 7'h12};
    else if (n == 11) begin cy = pm; v = {~pm, 7'h12}; end
    else if (n == 12) v = {pm, 7'h01};
    else v = enc(n + 1) | {pm, 7'h00};
  endtask

  function automatic int last_day(input logic [7:0] mon, input logic [7:0] yr);
    int m = digits_ok(mon) ? dec(mon) : 0;
    if (m == 2) return (dec(yr) % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m_pre = 0;
    m_f[0] = 8'h00; m_f[1] = 8'h00; m_f[2] = 8'h00; m_f[3] = 8'h01;
    m_f[4] = 8'h01; m_f[5] = 8'h00; m_f[6] = 8'h00;
    for (int i = 0; i < 6; i++) m_al[i] = 8'h00;
    for (int i = 0; i < 4; i++) m_ev[i] = 0;
    m_alarm = 0;
  endtask

  task automatic model_update();
    logic [7:0] nf [7];
    bit c[7];
    bit a[7];
    bit tick, hit;
    tick = en_auto && tick32k_i && run_i && (m_pre == TPS - 1);
    hit = m_ev[0];
    for (int i = 0; i < 6; i++) if (m_al[i] != m_f[i]) hit = 0;
    if (run_i && tick32k_i) m_pre = (m_pre == TPS - 1) ? 0 : m_pre + 1;
    for (int i = 0; i < 7; i++) nf[i] = m_f[i];
    nxt_plain(nf[0], 0, 59, c[0]);
    nxt_plain(nf[1], 0, 59, c[1]);
    if (mode12_i) nxt_h12(nf[2], c[2]);
    else nxt_plain(nf[2], 0, 23, c[2]);
    nxt_plain(nf[3], 1, last_day(m_f[4], m_f[5]), c[3]);
    nxt_plain(nf[4], 1, 12, c[4]);
    nxt_plain(nf[5], 0, 99, c[5]);
    nxt_plain(nf[6], 0, 6, c[6]);
    a[0] = tick;
    for (int i = 1; i < 6; i++) a[i] = a[i-1] && c[i-1];
    a[6] = a[3];
    for (int i = 0; i < 7; i++)
      if (wr[i]) m_f[i] = wr_data_i; else if (a[i]) m_f[i] = nf[i];
    for (int i = 0; i < 6; i++) if (awr[i]) m_al[i] = wr_data_i;
    for (int i = 0; i < 4; i++) m_ev[i] = a[i];
    m_alarm = hit;
  endtask

  task automatic chk(input string r, input string nm, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", r, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5", "sec", sec_o, m_f[0]);
    chk("R5", "min", min_o, m_f[1]);
    chk(mode12_i ? "R7" : "R6", "hour", hour_o, m_f[2]);
    chk("R8", "day", day_o, m_f[3]);
    chk("R8", "mon", mon_o, m_f[4]);
    chk("R8", "year", year_o, m_f[5]);
    chk("R9", "wday", wday_o, m_f[6]);
    chk("R2", "ev_sec", {7'd0, ev_sec_o}, {7'd0, m_ev[0]});
    chk("R5", "ev_min", {7'd0, ev_min_o}, {7'd0, m_ev[1]});
    chk("R5", "ev_hour", {7'd0, ev_hour_o}, {7'd0, m_ev[2]});
    chk("R6", "ev_day", {7'd0, ev_day_o}, {7'd0, m_ev[3]});
    chk("R4", "busy", {7'd0, busy_o}, {7'd0, run_i && (m_pre == TPS - 1)});
    chk("R11", "alarm", {7'd0, alarm_o}, {7'd0, m_alarm});
  endtask

  // inputs change at the falling edge; model steps at the rising edge
  task automatic step();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare_all();
    if (alarm_o) al_seen++;
    tick32k_i = en_auto ? ~tick32k_i : 1'b0;
  endtask

  task automatic wait_secs(input int n);
    int k = 0;
    while (k < n) begin
      step();
      if (m_ev[0]) k++;
    end
  endtask

  task automatic put(input int idx, input logic [7:0] v);
    wr[idx] = 1'b1; wr_data_i = v; step(); wr[idx] = 1'b0;
  endtask
  task automatic put_al(input int idx, input logic [7:0] v);
    awr[idx] = 1'b1; wr_data_i = v; step(); awr[idx] = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] yr, mo, dy, hr, mi, se);
    run_i = 1'b0;
    put(5, yr); put(4, mo); put(3, dy); put(2, hr); put(1, mi); put(0, se);
    run_i = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1", "sec", sec_o, 8'h00); chk("R1", "hour", hour_o, 8'h00);
    chk("R1", "day", day_o, 8'h01); chk("R1", "mon", mon_o, 8'h01);
    chk("R1", "year", year_o, 8'h00); chk("R1", "wday", wday_o, 8'h00);
    chk("R1", "busy", {7'd0, busy_o}, 8'h00); chk("R1", "alarm", {7'd0, alarm_o}, 8'h00);

    // R2 stepping
    run_i = 1'b1; en_auto = 1;
    wait_secs(3);
    chk("R2", "sec after 3 s", sec_o, 8'h03);

    // R3 hold while stopped
    run_i = 1'b0;
    repeat (40) step();
    chk("R3", "sec held", sec_o, 8'h03);
    chk("R4", "busy stopped", {7'd0, busy_o}, 8'h00);
    put(1, 8'h42);
    chk("R3", "write while stopped", min_o, 8'h42);

    // century rollover, R5 R6 R8 R9
    run_i = 1'b0; put(6, 8'h06);
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
    wait_secs(1);
    chk("R5", "sec 59", sec_o, 8'h59);
    wait_secs(1);
    chk("R6", "ev_day at midnight", {7'd0, ev_day_o}, 8'h01);
    chk("R6", "hour wrap", hour_o, 8'h00);
    chk("R8", "year wrap", year_o, 8'h00);
    chk("R8", "month wrap", mon_o, 8'h01);
    chk("R8", "day wrap", day_o, 8'h01);
    chk("R9", "wday wrap", wday_o, 8'h00);

    // R8 month lengths and leap years
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    wait_secs(1);
    chk("R8", "leap feb 29", day_o, 8'h29);
    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    wait_secs(1);
    chk("R8", "leap to mar", mon_o, 8'h03); chk("R8", "leap to mar day", day_o, 8'h01);
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    wait_secs(1);
    chk("R8", "non-leap to mar", mon_o, 8'h03);
    set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    wait_secs(1);
    chk("R8", "apr 30 to may", mon_o, 8'h05); chk("R8", "may day", day_o, 8'h01);

    // R7 twelve-hour mode
    mode12_i = 1'b1;
    set_time(8'h23, 8'h01, 8'h10, 8'h11, 8'h59, 8'h59);
    wait_secs(1);
    chk("R7", "11 AM to 12 PM", hour_o, 8'h92); chk("R7", "day kept", day_o, 8'h10);
    set_time(8'h23, 8'h01, 8'h10, 8'h91, 8'h59, 8'h59);
    wait_secs(1);
    chk("R7", "11 PM to 12 AM", hour_o, 8'h12); chk("R7", "day advanced", day_o, 8'h11);
    set_time(8'h23, 8'h01, 8'h10, 8'h12, 8'h59, 8'h59);
    wait_secs(1);
    chk("R7", "12 to 01", hour_o, 8'h01);

    // R10 illegal values
    set_time(8'h23, 8'h01, 8'h10, 8'h15, 8'h59, 8'h59);
    wait_secs(1);
    chk("R10", "bad 12h hour", hour_o, 8'h12); chk("R10", "no day carry", day_o, 8'h10);
    mode12_i = 1'b0;
    set_time(8'h23, 8'h01, 8'h10, 8'h05, 8'h10, 8'h7A);
    chk("R10", "stored as written", sec_o, 8'h7A);
    wait_secs(1);
    chk("R10", "bad sec wraps", sec_o, 8'h00); chk("R10", "bad sec carries", min_o, 8'h11);

    // R11 alarm
    run_i = 1'b0;
    put_al(5, 8'h24); put_al(4, 8'h06); put_al(3, 8'h15);
    put_al(2, 8'h10); put_al(1, 8'h20); put_al(0, 8'h32);
    set_time(8'h24, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    al_seen = 0;
    wait_secs(2);
    step();
    chk("R11", "alarm pulse", {7'd0, alarm_o}, 8'h01);
    step();
    chk("R11", "alarm one cycle", {7'd0, alarm_o}, 8'h00);
    al_seen = 0;
    set_time(8'h24, 8'h06, 8'h15, 8'h10, 8'h20, 8'h32);
    repeat (TPS) step();
    chk("R11", "write-equal no alarm", al_seen[7:0], 8'h00);
    put_al(5, 8'h25);
    set_time(8'h24, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    al_seen = 0;
    wait_secs(3);
    step();
    chk("R11", "year mismatch no alarm", al_seen[7:0], 8'h00);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule